// File: doc/BRIEF.md
# Instruction Group Dispatch and Completion Tracker

This block takes a stream of decoded instructions presented on three parallel lanes and, once per clock, packs the leading lanes into one dispatch group of up to three instructions. A per-lane break flag forces an instruction to open a new group, so a group can close with fewer than three members. Each group that dispatches is given a slot in a sixteen-entry circular tracking table. The index of that slot is the group identifier sent out with the group.

Downstream execution reports each instruction's completion by naming its group identifier and its slot within the group. An entry stays allocated until every member of its group has reported. Groups leave the table only from the oldest end, at most one per clock, and each departure is shown as a retire pulse carrying the group identifier. When all sixteen entries are in use, no group is taken. A flush empties the table and restarts identifier allocation at zero.

Top module: `dispatch_tracker`

## Requirements
- R1: After reset, `grp_valid` and `ret_valid` are low, and `in_take` is 0 while no lane is valid.
- R2: The group taken in a cycle is lanes 0..k-1. Lane 0 is always a member when valid. Lane i>0 joins only if every lane below it joined, lane i is valid and its break bit is low. `in_take` equals k. In `grp_data`, slot i holds lane i's instruction (slot 0 in the low bits), and unused slots are zero.
- R3: A set break bit on lane i>0 starts a new group at lane i. The break bit of lane 0 has no effect.
- R4: A group taken in a cycle appears on `grp_valid`/`grp_gid`/`grp_count`/`grp_data` in the next cycle. Group identifiers are given out in sequence and wrap from 15 to 0.
- R5: A group retires only when every one of its member slots has reported finished. `ret_valid` rises in the cycle after the cycle in which the last report is sampled.
- R6: Groups retire oldest first. A finished younger group waits while an older group is still outstanding.
- R7: At most one group retires per cycle. Groups that are ready back to back retire on consecutive cycles.
- R8: While 16 groups are outstanding, `in_take` is 0 and no group is dispatched.
- R9: A flush blocks dispatch in its own cycle, discards every outstanding group without retiring it, and makes the next identifier 0.
- R10: A finish report that names an unallocated entry, a slot beyond the group's size, or a slot that has already reported, has no effect.
- R11: A dispatch and a retire may happen in the same cycle. The occupancy then stays unchanged, so with 15 entries in use a further group is still accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all outstanding groups |
| in_valid | input | 3 | Per-lane instruction valid, bit i = lane i |
| in_brk | input | 3 | Per-lane group-break flag |
| in_data | input | 48 | Lane instructions, lane i in bits 16i+15:16i |
| in_take | output | 2 | Number of lanes consumed this cycle |
| fin_valid | input | 1 | Finish report strobe |
| fin_gid | input | 4 | Group identifier of the finished instruction |
| fin_slot | input | 2 | Slot of the finished instruction within its group |
| grp_valid | output | 1 | A dispatched group is presented |
| grp_gid | output | 4 | Identifier of the presented group |
| grp_count | output | 2 | Number of instructions in the presented group |
| grp_data | output | 48 | Instructions of the presented group |
| ret_valid | output | 1 | A group retires |
| ret_gid | output | 4 | Identifier of the retiring group |

## Verification
The dispatch of a new group and the retirement of the oldest one can both happen on the same clock edge. In that case the table's occupancy must neither drift nor cause a false stall. The bench fills the table to fifteen entries, then completes the oldest group so that it becomes ready just as another group is presented. It then checks that the retire pulse and the new group appear together, that the following group is still accepted with its identifier wrapped to 0, and that the group after that is refused because all sixteen entries are now in use.

// File: rtl/dt_pkg.sv
`timescale 1ns/1ps
package dt_pkg;
   localparam int DEF_LANES = 3;
   localparam int DEF_DEPTH = 16;
   localparam int DEF_IW    = 16;

   function automatic int slot_w(input int lanes);
      return (lanes > 1) ? $clog2(lanes) : 1;
   endfunction
endpackage

// File: rtl/dt_group_former.sv
`timescale 1ns/1ps
module dt_group_former #(
   parameter int LANES = dt_pkg::DEF_LANES,
   parameter int CW    = $clog2(LANES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] lane_vld,
   input  logic [LANES-1:0] lane_brk,
   input  logic             allow,
   output logic             accept,
   output logic [LANES-1:0] take_mask,
   output logic [CW-1:0]    take_cnt
);
   logic [LANES-1:0] join_c;

   // Membership chain: a lane joins only behind an unbroken run of members.
   assign join_c[0] = lane_vld[0];
   for (genvar i = 1; i < LANES; i++) begin : g_chain
      assign join_c[i] = join_c[i-1] & lane_vld[i] & ~lane_brk[i];
   end

   assign accept    = allow & join_c[0];
   assign take_mask = accept ? join_c : '0;

   always_comb begin
      take_cnt = '0;
      for (int i = 0; i < LANES; i++) take_cnt = take_cnt + CW'(take_mask[i]);
   end

   // R2: members always form a contiguous run starting at slot 0
   p_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((take_mask & (take_mask + 1'b1)) == '0));
endmodule

// File: rtl/dt_entry_table.sv
`timescale 1ns/1ps
module dt_entry_table #(
   parameter int LANES = dt_pkg::DEF_LANES,
   parameter int DEPTH = dt_pkg::DEF_DEPTH,
   parameter int AW    = $clog2(DEPTH),
   parameter int SW    = dt_pkg::slot_w(LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             alloc,
   input  logic [LANES-1:0] alloc_mask,
   input  logic             fin_valid,
   input  logic [AW-1:0]    fin_gid,
   input  logic [SW-1:0]    fin_slot,
   output logic             full,
   output logic [AW-1:0]    tail,
   output logic             retire,
   output logic [AW-1:0]    head
);
   localparam int CNT_W = AW + 1;

   logic [DEPTH-1:0] vld_q;
   logic [LANES-1:0] need_q [DEPTH];
   logic [LANES-1:0] done_q [DEPTH];
   logic [AW-1:0]    head_q, tail_q;
   logic [CNT_W-1:0] cnt_q;
   logic [LANES-1:0] fin_bits;
   logic             fin_hit;

   always_comb begin
      for (int s = 0; s < LANES; s++) fin_bits[s] = (fin_slot == SW'(s));
   end

   // A report counts only for a live entry and a slot the group really owns.
   assign fin_hit = fin_valid & vld_q[fin_gid] & (|(fin_bits & need_q[fin_gid]));
   assign retire  = vld_q[head_q] & (done_q[head_q] == need_q[head_q]);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign head    = head_q;
   assign tail    = tail_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= '0;
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
         for (int e = 0; e < DEPTH; e++) begin
            need_q[e] <= '0;
            done_q[e] <= '0;
         end
      end else if (flush) begin
         vld_q  <= '0;
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (alloc && tail_q == AW'(e)) begin
               vld_q[e]  <= 1'b1;
               need_q[e] <= alloc_mask;
               done_q[e] <= '0;
            end else if (retire && head_q == AW'(e)) begin
               vld_q[e] <= 1'b0;
            end else if (fin_hit && fin_gid == AW'(e)) begin
               done_q[e] <= done_q[e] | fin_bits;
            end
         end
         if (alloc)  tail_q <= tail_q + 1'b1;
         if (retire) head_q <= head_q + 1'b1;
         cnt_q <= cnt_q + CNT_W'(alloc) - CNT_W'(retire);
      end
   end

   // R8: occupancy never exceeds the table size
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q <= CNT_W'(DEPTH)));
   // R9: a flush leaves the table empty
   p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt_q == '0 && vld_q == '0));
   // R7: a retirement advances the oldest pointer by exactly one
   p_head_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && !flush) |=> (head_q == $past(head_q) + 1'b1));
endmodule

// File: rtl/dispatch_tracker.sv
`timescale 1ns/1ps
module dispatch_tracker #(
   parameter int LANES = dt_pkg::DEF_LANES,
   parameter int DEPTH = dt_pkg::DEF_DEPTH,
   parameter int IW    = dt_pkg::DEF_IW,
   parameter int AW    = $clog2(DEPTH),
   parameter int SW    = dt_pkg::slot_w(LANES),
   parameter int CW    = $clog2(LANES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic [LANES-1:0]    in_valid,
   input  logic [LANES-1:0]    in_brk,
   input  logic [LANES*IW-1:0] in_data,
   output logic [CW-1:0]       in_take,
   input  logic                fin_valid,
   input  logic [AW-1:0]       fin_gid,
   input  logic [SW-1:0]       fin_slot,
   output logic                grp_valid,
   output logic [AW-1:0]       grp_gid,
   output logic [CW-1:0]       grp_count,
   output logic [LANES*IW-1:0] grp_data,
   output logic                ret_valid,
   output logic [AW-1:0]       ret_gid
);
   initial begin : param_check
      if (LANES < 1 || IW < 1)
         $fatal(1, "dispatch_tracker: LANES and IW must be positive");
      if (DEPTH < 2 || DEPTH != (1 << AW))
         $fatal(1, "dispatch_tracker: DEPTH must be a power of two, at least 2");
   end

   logic             tbl_full, tbl_retire, accept;
   logic [AW-1:0]    tbl_tail, tbl_head;
   logic [LANES-1:0] take_mask;
   logic [CW-1:0]    take_cnt;
   logic [LANES*IW-1:0] pack_data;

   dt_group_former #(.LANES(LANES), .CW(CW)) u_former (
      .clk(clk), .rst_n(rst_n),
      .lane_vld(in_valid), .lane_brk(in_brk),
      .allow(!tbl_full && !flush),
      .accept(accept), .take_mask(take_mask), .take_cnt(take_cnt)
   );

   dt_entry_table #(.LANES(LANES), .DEPTH(DEPTH), .AW(AW), .SW(SW)) u_table (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .alloc(accept), .alloc_mask(take_mask),
      .fin_valid(fin_valid), .fin_gid(fin_gid), .fin_slot(fin_slot),
      .full(tbl_full), .tail(tbl_tail), .retire(tbl_retire), .head(tbl_head)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_pack
      assign pack_data[i*IW +: IW] = take_mask[i] ? in_data[i*IW +: IW] : '0;
   end

   assign in_take = take_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_valid <= 1'b0;
         grp_gid   <= '0;
         grp_count <= '0;
         grp_data  <= '0;
         ret_valid <= 1'b0;
         ret_gid   <= '0;
      end else begin
         grp_valid <= accept;
         ret_valid <= tbl_retire && !flush;
         if (accept) begin
            grp_gid   <= tbl_tail;
            grp_count <= take_cnt;
            grp_data  <= pack_data;
         end
         if (tbl_retire) ret_gid <= tbl_head;
      end
   end

   // R8: a full table must stop the former from taking lanes
   p_stall_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_full |-> (in_take == '0));
   // R4: back-to-back groups carry consecutive identifiers
   p_gid_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_valid && $past(grp_valid)) |-> (grp_gid == $past(grp_gid) + 1'b1));
   // R6: back-to-back retirements are in identifier order
   p_ret_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && $past(ret_valid)) |-> (ret_gid == $past(ret_gid) + 1'b1));
   // R9: nothing is dispatched or retired right after a flush
   p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!grp_valid && !ret_valid));
endmodule

// File: tb/dispatch_tracker_test.sv
`timescale 1ns/1ps
module dispatch_tracker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [2:0]  in_valid = '0;
   logic [2:0]  in_brk = '0;
   logic [47:0] in_data = '0;
   logic [1:0]  in_take;
   logic        fin_valid = 1'b0;
   logic [3:0]  fin_gid = '0;
   logic [1:0]  fin_slot = '0;
   logic        grp_valid;
   logic [3:0]  grp_gid;
   logic [1:0]  grp_count;
   logic [47:0] grp_data;
   logic        ret_valid;
   logic [3:0]  ret_gid;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;   // 50 MHz

   dispatch_tracker uut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .in_valid(in_valid), .in_brk(in_brk), .in_data(in_data), .in_take(in_take),
      .fin_valid(fin_valid), .fin_gid(fin_gid), .fin_slot(fin_slot),
      .grp_valid(grp_valid), .grp_gid(grp_gid), .grp_count(grp_count), .grp_data(grp_data),
      .ret_valid(ret_valid), .ret_gid(ret_gid)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic present(input logic [2:0] v, input logic [2:0] b);
      in_valid = v;
      in_brk   = b;
      in_data  = {16'hc002, 16'hc001, 16'hc000};
      #1;
   endtask

   task automatic idle_in();
      in_valid = '0;
      in_brk   = '0;
      in_data  = '0;
   endtask

   task automatic finish(input int gid, input int slot);
      fin_valid = 1'b1;
      fin_gid   = 4'(gid);
      fin_slot  = 2'(slot);
      tick();
      fin_valid = 1'b0;
   endtask

   task automatic do_flush();
      flush = 1'b1;
      tick();
      flush = 1'b0;
   endtask

   task automatic expect_grp(input string req, input int gid, input int cnt);
      check(grp_valid == 1'b1, req, grp_valid, 1);
      check(grp_gid == 4'(gid), req, grp_gid, gid);
      check(grp_count == 2'(cnt), req, grp_count, cnt);
   endtask

   task automatic t_reset();
      #1;
      check(grp_valid == 1'b0, "R1 grp_valid", grp_valid, 0);
      check(ret_valid == 1'b0, "R1 ret_valid", ret_valid, 0);
      check(in_take == 2'd0, "R1 in_take", in_take, 0);
   endtask

   task automatic t_forming();
      present(3'b111, 3'b000);
      check(in_take == 2'd3, "R2 full group take", in_take, 3);
      tick();
      idle_in();
      expect_grp("R2 three wide", 0, 3);
      check(grp_data == {16'hc002, 16'hc001, 16'hc000}, "R2 data order", grp_data, 48'hc002c001c000);
      present(3'b011, 3'b000);
      check(in_take == 2'd2, "R2 stops at invalid lane", in_take, 2);
      tick();
      idle_in();
      expect_grp("R4 second id", 1, 2);
      check(grp_data == {16'h0, 16'hc001, 16'hc000}, "R2 unused slot zero", grp_data, 48'h0000c001c000);
      present(3'b111, 3'b010);
      check(in_take == 2'd1, "R3 break on lane1", in_take, 1);
      tick();
      idle_in();
      expect_grp("R3 early close", 2, 1);
      present(3'b111, 3'b100);
      check(in_take == 2'd2, "R3 break on lane2", in_take, 2);
      tick();
      present(3'b111, 3'b001);
      check(in_take == 2'd3, "R3 lane0 break ignored", in_take, 3);
      tick();
      idle_in();
      expect_grp("R3 lane0 break ignored", 4, 3);
      tick();
      check(grp_valid == 1'b0, "R4 no group without input", grp_valid, 0);
   endtask

   task automatic t_retire();
      do_flush();
      present(3'b111, 3'b000);
      tick();
      expect_grp("R9 id restarts", 0, 3);
      present(3'b001, 3'b000);
      tick();
      idle_in();
      finish(1, 0);
      check(ret_valid == 1'b0, "R6 young waits", ret_valid, 0);
      tick();
      check(ret_valid == 1'b0, "R6 young still waits", ret_valid, 0);
      finish(0, 0);
      finish(0, 1);
      finish(0, 1);
      check(ret_valid == 1'b0, "R10 repeat no retire", ret_valid, 0);
      finish(0, 2);
      check(ret_valid == 1'b0, "R5 not before last report", ret_valid, 0);
      tick();
      check(ret_valid == 1'b1 && ret_gid == 4'd0, "R5 retire oldest", {ret_valid, ret_gid}, 5'h10);
      tick();
      check(ret_valid == 1'b1 && ret_gid == 4'd1, "R7 next cycle retire", {ret_valid, ret_gid}, 5'h11);
      tick();
      check(ret_valid == 1'b0, "R7 single pulse", ret_valid, 0);
   endtask

   task automatic t_ignored();
      present(3'b011, 3'b000);
      tick();
      idle_in();
      expect_grp("R4 id continues", 2, 2);
      finish(2, 2);
      finish(9, 0);
      finish(2, 0);
      finish(2, 0);
      tick();
      tick();
      check(ret_valid == 1'b0, "R10 bogus reports ignored", ret_valid, 0);
      finish(2, 1);
      tick();
      check(ret_valid == 1'b1 && ret_gid == 4'd2, "R10 real completion", {ret_valid, ret_gid}, 5'h12);
   endtask

   task automatic t_full_and_overlap();
      do_flush();
      for (int g = 0; g < 15; g++) begin
         present(3'b001, 3'b000);
         tick();
      end
      idle_in();
      finish(0, 0);
      present(3'b001, 3'b000);
      check(in_take == 2'd1, "R11 accepts at fifteen", in_take, 1);
      tick();
      check(ret_valid == 1'b1 && ret_gid == 4'd0, "R11 retire together", {ret_valid, ret_gid}, 5'h10);
      expect_grp("R11 dispatch together", 15, 1);
      present(3'b001, 3'b000);
      check(in_take == 2'd1, "R11 count unchanged", in_take, 1);
      tick();
      expect_grp("R4 wrap to zero", 0, 1);
      present(3'b111, 3'b000);
      check(in_take == 2'd0, "R8 stall when full", in_take, 0);
      tick();
      check(grp_valid == 1'b0, "R8 no dispatch when full", grp_valid, 0);
      idle_in();
   endtask

   task automatic t_flush();
      finish(1, 0);
      flush = 1'b1;
      present(3'b001, 3'b000);
      check(in_take == 2'd0, "R9 blocked in flush cycle", in_take, 0);
      tick();
      flush = 1'b0;
      idle_in();
      check(ret_valid == 1'b0 && grp_valid == 1'b0, "R9 quiet after flush", {ret_valid, grp_valid}, 0);
      tick();
      check(ret_valid == 1'b0, "R9 flushed group not retired", ret_valid, 0);
      present(3'b001, 3'b000);
      check(in_take == 2'd1, "R9 table empty", in_take, 1);
      tick();
      idle_in();
      expect_grp("R9 id zero", 0, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_forming();
      t_retire();
      t_ignored();
      t_full_and_overlap();
      t_flush();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule